// File: doc/BRIEF.md
# Integer ALU with Trapping Overflow Capture

This block is the integer execute unit of a scalar datapath. It takes two 32-bit operands, a 3-bit operation code, the address of the instruction being executed and a trap-enable bit. It returns a registered result with zero, carry and overflow flags. Addition and subtraction share one carry-select adder. The low 16 bits ripple on their own. Two 16-bit upper sections run at the same time, one assuming a carry-in of 0 and one assuming 1. The carry leaving the low section picks which upper sum and which carry-out are used.

Signed and unsigned arithmetic compute the same bits. The instruction decoder tells them apart by driving `in_trap_en` high for the trapping (signed) forms. When an accepted trapping add or subtract overflows, the block pulses `exc_pulse` for one cycle, and in the same edge it stores that instruction's address in the exception address register `epc`. The register holds its value until reset or the next trapping overflow.

Operations flow through a one-deep valid/ready stage. An operation is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output register and its flags stay frozen. An operation offered during such a stall is not taken and has no effect.

Top module: `alu_trap_unit`

## Requirements
- R1: Op 3'b010 (add) returns A+B modulo 2^32, and the carry flag shows bit 32 of the sum, including when a carry crosses from bit 15 into bit 16.
- R2: Op 3'b110 (subtract) returns A+~B+1, and the carry flag shows bit 32 of that sum (1 means no borrow).
- R3: The overflow flag is 1 only for add and subtract, and only when the two adder inputs (B after any inversion) share a sign bit that differs from the result's sign bit. It is 0 for every other op.
- R4: The logic ops are 3'b000 A AND B, 3'b001 A OR B, 3'b011 NOR of A and B, 3'b100 A AND NOT B, and 3'b101 A OR NOT B. For all of them the carry flag reads 0.
- R5: Op 3'b111 (set-less-than) returns 1 in bit 0 when (sign of A−B) XOR (signed overflow of A−B) is 1, and 0 otherwise. Bits 31..1 are always 0.
- R6: The zero flag is 1 exactly when all 32 result bits are 0.
- R7: An accepted add or subtract with `in_trap_en`=1 that overflows makes `exc_pulse` high for exactly the cycle in which its result is first presented, and writes its `in_pc` into `epc` on the same edge.
- R8: With `in_trap_en`=0, an overflowing add or subtract raises neither `exc_pulse` nor any change of `epc`, but it still reports the overflow flag. Set-less-than never traps.
- R9: `epc` keeps its value through operations that do not trap. Reset clears it to 0.
- R10: `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid`=1 and `out_ready`=0, the result and flags hold, and an offered operation is not taken: it raises no exception and leaves `epc` unchanged.
- R11: After reset, `out_valid`=0, `exc_pulse`=0, `epc`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation will be taken this cycle |
| in_op | input | 3 | Operation code |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_pc | input | 32 | Address of the instruction being executed |
| in_trap_en | input | 1 | 1 for trapping (signed) arithmetic |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Result |
| out_zero | output | 1 | Result is all zeros |
| out_carry | output | 1 | Adder carry-out (add and subtract only) |
| out_ovf | output | 1 | Signed overflow (add and subtract only) |
| exc_pulse | output | 1 | One-cycle overflow exception |
| epc | output | 32 | Address of the last instruction that trapped |

## Verification
Exception capture and back-pressure can meet in the same cycle. This happens when a trapping overflow is offered while the output register is stalled. The bench holds `out_ready` low behind an ordinary result and then offers an overflowing trapping add. It checks that the held result, `exc_pulse` and `epc` do not move. It then raises `out_ready`, so that the drain and the accept happen on one edge, and checks that the pulse and the captured address appear together with the overflowed sum, and that the pulse is gone one cycle later.

// File: rtl/alu_trap_pkg.sv
package alu_trap_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_NOR  = 3'b011,
    OP_ANDN = 3'b100,
    OP_ORN  = 3'b101,
    OP_SUB  = 3'b110,
    OP_SLT  = 3'b111
  } alu_op_e;

  localparam int unsigned OP_W = 3;
endpackage

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1]   = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign cout = c[W];
endmodule

// File: rtl/carry_select_adder.sv
module carry_select_adder #(
  parameter int unsigned W    = 32,
  parameter int unsigned LO_W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int unsigned HI_W = W - LO_W;

  logic [LO_W-1:0] lo_sum;
  logic            lo_co;
  logic [HI_W-1:0] hi_sum [2];
  logic            hi_co  [2];

  ripple_adder #(.W(LO_W)) u_lo (
    .a(a[LO_W-1:0]), .b(b[LO_W-1:0]), .cin(cin),
    .sum(lo_sum), .cout(lo_co)
  );

  for (genvar k = 0; k < 2; k++) begin : g_spec
    ripple_adder #(.W(HI_W)) u_hi (
      .a(a[W-1:LO_W]), .b(b[W-1:LO_W]), .cin(k == 1),
      .sum(hi_sum[k]), .cout(hi_co[k])
    );
  end

  assign sum  = {(lo_co ? hi_sum[1] : hi_sum[0]), lo_sum};
  assign cout = lo_co ? hi_co[1] : hi_co[0];

  // R1: selected halves must agree with a plain wide sum
  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      p_csel_sum_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
        else $error("carry-select sum mismatch");
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_trap_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned LO_W = 16
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [OP_W-1:0] op,
  output logic [W-1:0]    result,
  output logic            zero,
  output logic            carry,
  output logic            ovf
);
  logic         b_inv;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         co;
  logic         add_ovf;
  logic         is_arith;
  logic         less;

  assign b_inv = op[2];
  assign b_eff = b_inv ? ~b : b;

  carry_select_adder #(.W(W), .LO_W(LO_W)) u_add (
    .a(a), .b(b_eff), .cin(b_inv), .sum(sum), .cout(co)
  );

  assign add_ovf  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);
  assign less     = sum[W-1] ^ add_ovf;

  always_comb begin
    if (op == OP_SLT) begin
      result = {{(W-1){1'b0}}, less};
    end else begin
      unique case (op[1:0])
        2'd0:    result = a & b_eff;
        2'd1:    result = a | b_eff;
        2'd2:    result = sum;
        default: result = ~(a | b_eff);
      endcase
    end
  end

  assign zero  = ~|result;
  assign carry = is_arith & co;
  assign ovf   = is_arith & add_ovf;

  always_comb begin
    if (!$isunknown({a, b, op})) begin
      // R3: overflow only with like-signed inputs and a flipped result sign
      p_ovf_sign_r3: assert (!ovf || ((a[W-1] == b_eff[W-1]) && (result[W-1] != a[W-1])))
        else $error("overflow without sign condition");
      // R5: set-less-than upper bits stay clear
      p_slt_upper_r5: assert ((op != OP_SLT) || (result[W-1:1] == '0))
        else $error("set-less-than upper bits set");
    end
  end
endmodule

// File: rtl/alu_trap_unit.sv
module alu_trap_unit
  import alu_trap_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned LO_W = W / 2,
  parameter int unsigned AW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  input  logic [AW-1:0]   in_pc,
  input  logic            in_trap_en,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_result,
  output logic            out_zero,
  output logic            out_carry,
  output logic            out_ovf,
  output logic            exc_pulse,
  output logic [AW-1:0]   epc
);
  logic [W-1:0] c_result;
  logic         c_zero;
  logic         c_carry;
  logic         c_ovf;
  logic         accept;
  logic         trap_hit;

  alu_core #(.W(W), .LO_W(LO_W)) u_core (
    .a(in_a), .b(in_b), .op(in_op),
    .result(c_result), .zero(c_zero), .carry(c_carry), .ovf(c_ovf)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign trap_hit = accept && in_trap_en && c_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_zero   <= 1'b0;
      out_carry  <= 1'b0;
      out_ovf    <= 1'b0;
      exc_pulse  <= 1'b0;
      epc        <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        out_result <= c_result;
        out_zero   <= c_zero;
        out_carry  <= c_carry;
        out_ovf    <= c_ovf;
      end
      exc_pulse <= trap_hit;
      if (trap_hit) epc <= in_pc;
    end
  end

  // R7: an exception is only presented alongside an overflowed result
  p_exc_with_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> (out_valid && out_ovf))
    else $error("exception without overflow result");

  // R9: the exception address moves only on a trap
  p_epc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(epc) |-> exc_pulse)
    else $error("epc changed without trap");

  // R10: a stalled output holds and an untaken offer cannot trap
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && !exc_pulse))
    else $error("stall not honoured");

  // R11: ready whenever the output stage is empty
  p_ready_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready)
    else $error("not ready while empty");
endmodule

// File: tb/alu_trap_unit_bench.sv
module alu_trap_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'b000;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [31:0] in_pc = '0;
  logic        in_trap_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_zero;
  logic        out_carry;
  logic        out_ovf;
  logic        exc_pulse;
  logic [31:0] epc;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] exp_epc = '0;

  always #5 clk = ~clk;

  alu_trap_unit u_alu_trap_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_pc(in_pc),
    .in_trap_en(in_trap_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_zero(out_zero), .out_carry(out_carry),
    .out_ovf(out_ovf), .exc_pulse(exc_pulse), .epc(epc)
  );

  // {op, a, b, expected result}
  localparam int NV = 15;
  localparam logic [98:0] VEC [NV] = '{
    {3'b000, 32'hF0F01234, 32'h0FF0FF00, 32'h00F01200},
    {3'b001, 32'hF0000001, 32'h00001000, 32'hF0001001},
    {3'b011, 32'h00000000, 32'h00000000, 32'hFFFFFFFF},
    {3'b010, 32'h00000007, 32'h00000006, 32'h0000000D},
    {3'b010, 32'h0000FFFF, 32'h00000001, 32'h00010000},
    {3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000},
    {3'b110, 32'h00000007, 32'h00000006, 32'h00000001},
    {3'b110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF},
    {3'b110, 32'h12345678, 32'h12345678, 32'h00000000},
    {3'b111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001},
    {3'b111, 32'h80000000, 32'h00000001, 32'h00000001},
    {3'b111, 32'h00000005, 32'h00000003, 32'h00000000},
    {3'b100, 32'hFFFFFFFF, 32'h0000FFFF, 32'hFFFF0000},
    {3'b101, 32'h00000000, 32'hFFFF0000, 32'h0000FFFF}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // returns {carry, ovf} from the requirement rules
  function automatic logic [1:0] flags(input logic [2:0] op, input logic [31:0] a,
                                       input logic [31:0] b);
    logic [31:0] bb;
    logic [32:0] s;
    logic        v;
    logic        ar;
    bb = op[2] ? ~b : b;
    s  = {1'b0, a} + {1'b0, bb} + {32'd0, op[2]};
    v  = (a[31] == bb[31]) && (s[31] != a[31]);
    ar = (op == 3'b010) || (op == 3'b110);
    return {ar & s[32], ar & v};
  endfunction

  function automatic string tag(input logic [2:0] op);
    if (op == 3'b010) return "R1";
    if (op == 3'b110) return "R2";
    if (op == 3'b111) return "R5";
    return "R4";
  endfunction

  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] pc, input logic trap);
    @(negedge clk);
    in_op = op; in_a = a; in_b = b; in_pc = pc; in_trap_en = trap; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11", "out_valid", 32'(out_valid), 32'd0);
    chk(exc_pulse == 1'b0, "R11", "exc_pulse", 32'(exc_pulse), 32'd0);
    chk(epc == 32'd0, "R11", "epc", epc, 32'd0);
    chk(in_ready == 1'b1, "R11", "in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  op;
      logic [31:0] a, b, er, pc;
      logic [1:0]  fl;
      {op, a, b, er} = VEC[i];
      pc = 32'h400 + 32'(i) * 4;
      fl = flags(op, a, b);
      issue(op, a, b, pc, 1'b1);
      if (fl[0]) exp_epc = pc;
      chk(out_valid == 1'b1, "R10", "out_valid", 32'(out_valid), 32'd1);
      chk(out_result == er, tag(op), "result", out_result, er);
      chk(out_zero == (er == 32'd0), "R6", "zero", 32'(out_zero), 32'(er == 32'd0));
      chk(out_carry == fl[1], tag(op), "carry", 32'(out_carry), 32'(fl[1]));
      chk(out_ovf == fl[0], "R3", "ovf", 32'(out_ovf), 32'(fl[0]));
      chk(exc_pulse == fl[0], "R7", "exc_pulse", 32'(exc_pulse), 32'(fl[0]));
      chk(epc == exp_epc, "R9", "epc", epc, exp_epc);
    end

    // R8: overflow without trap enable
    issue(3'b110, 32'h80000000, 32'h00000001, 32'h00001234, 1'b0);
    chk(out_ovf == 1'b1, "R8", "ovf flag", 32'(out_ovf), 32'd1);
    chk(exc_pulse == 1'b0, "R8", "no exception", 32'(exc_pulse), 32'd0);
    chk(epc == exp_epc, "R8", "epc kept", epc, exp_epc);

    // R9: trapping op without overflow keeps epc
    issue(3'b010, 32'd1, 32'd1, 32'h00009999, 1'b1);
    chk(exc_pulse == 1'b0, "R9", "no exception", 32'(exc_pulse), 32'd0);
    chk(epc == exp_epc, "R9", "epc kept", epc, exp_epc);

    // R10 with R7: trapping overflow offered during a stall
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 3'b010; in_a = 32'd2; in_b = 32'd3; in_pc = 32'h0; in_trap_en = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_op = 3'b010; in_a = 32'h7FFFFFFF; in_b = 32'd1; in_pc = 32'h000BEEF0;
    in_trap_en = 1'b1;
    chk(in_ready == 1'b0, "R10", "in_ready stalled", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk(out_result == 32'd5, "R10", "held result", out_result, 32'd5);
    chk(exc_pulse == 1'b0, "R10", "no trap while stalled", 32'(exc_pulse), 32'd0);
    chk(epc == exp_epc, "R10", "epc while stalled", epc, exp_epc);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_epc = 32'h000BEEF0;
    chk(out_result == 32'h80000000, "R10", "drained result", out_result, 32'h80000000);
    chk(exc_pulse == 1'b1, "R7", "exception after drain", 32'(exc_pulse), 32'd1);
    chk(epc == exp_epc, "R7", "epc captured", epc, exp_epc);
    @(negedge clk);
    chk(exc_pulse == 1'b0, "R7", "pulse one cycle", 32'(exc_pulse), 32'd0);
    chk(out_valid == 1'b0, "R10", "emptied", 32'(out_valid), 32'd0);
    chk(epc == exp_epc, "R9", "epc held", epc, exp_epc);

    // R9 / R11: reset clears epc
    rst_n = 1'b0;
    @(negedge clk);
    chk(epc == 32'd0, "R9", "epc reset", epc, 32'd0);
    chk(out_valid == 1'b0, "R11", "out_valid reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule